// File: doc/BRIEF.md
# Serial 0-1-0 Detector with Permanent 1-0-0 Lockout

This block watches a one-bit serial stream and takes one bit on every rising clock edge. It raises its match output when the three most recent bits, oldest first, are 0, 1 and 0. Matches may overlap, so the tail of one match can start the next. The stream 0,1,0,1,0 therefore matches twice.

A second pattern acts as a kill switch. Once the bits 1, 0, 0 have arrived in a row, the detector goes quiet. It ignores every later bit until a synchronous reset re-arms it.

The output is a Moore output decoded from the registered state. It rises in the clock cycle after the edge that samples the completing bit, and it stays steady while the input moves between edges. A parameter selects dense binary or one-hot state storage. Both choices behave the same at the ports.

Top module: `gated_seq_detect`

## Requirements
- R1: An active-high reset sampled at a rising edge puts the block in its empty-history state, and match_out is 0 after that edge.
- R2: match_out is 1 after an edge exactly when the bits sampled at that edge and the two edges before it, with no reset among them, are 0, 1, 0 in that order and no lockout is in force.
- R3: Overlapping matches are reported: after reset, the stream 0,1,0,1,0 gives match_out 0,0,1,0,1.
- R4: Bits sampled before a reset do not count toward a pattern: the stream 0,1, then a reset, then 0 leaves match_out at 0.
- R5: Once 1,0,0 has been sampled on three consecutive non-reset edges, match_out stays 0 for every later bit until reset.
- R6: A reset clears the lockout, and 0,1,0 after it raises match_out again.
- R7: Between rising edges match_out does not change when bit_in changes (Moore output).
- R8: After reset, input 0,0,1,0,1,0,1,0,0,1,0 gives output 0,0,0,1,0,1,0,1,0,0,0, and input 1,1,0,1,1,0,1,0,0,1,0 gives 0,0,0,0,0,0,0,1,0,0,0, each output bit taken after the edge that samples the matching input bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per edge |
| rst | input | 1 | Synchronous active-high reset; clears history and lockout |
| bit_in | input | 1 | Serial data bit |
| match_out | output | 1 | High while the last three bits were 0,1,0 and no lockout |

## Verification
A wrong internal state can show itself at the ports on any of three later edges: a missed or false match, a second overlapped match that never appears, or a lockout that starts early or late. Any corrupted suffix state reaches match_out within at most three edges, as soon as the bits that follow it diverge. A lockout that fails to stick shows only when a later 0,1,0 arrives. So the random stream runs long after each lockout and resets only rarely. Checks taken in the middle of a cycle, after bit_in has changed, expose any path from the input straight to the output.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

   localparam int GSD_NS = 7;
   localparam int GSD_SW = 3;

   // Each state names the longest input suffix that can still lead to a
   // match or to the lockout.
   typedef enum logic [GSD_SW-1:0] {
      ST_EMPTY = 3'd0,  // nothing useful seen since reset
      ST_Z     = 3'd1,  // suffix 0 (or 00)
      ST_O     = 3'd2,  // suffix 1
      ST_ZO    = 3'd3,  // suffix 01
      ST_OZ    = 3'd4,  // suffix 10
      ST_HIT   = 3'd5,  // suffix 010, match reported
      ST_LOCK  = 3'd6   // 100 was seen, absorbing
   } gsd_state_e;

   localparam logic [GSD_SW-1:0] GSD_LAST = 3'(GSD_NS - 1);

endpackage

// File: rtl/gsd_next.sv
module gsd_next
   import gsd_pkg::*;
(
   input  gsd_state_e cur,
   input  logic       bit_in,
   output gsd_state_e nxt,
   output logic       match,
   output logic       locked
);

   always_comb begin
      case (cur)
         ST_EMPTY: nxt = bit_in ? ST_O  : ST_Z;
         ST_Z:     nxt = bit_in ? ST_ZO : ST_Z;
         ST_O:     nxt = bit_in ? ST_O  : ST_OZ;
         ST_ZO:    nxt = bit_in ? ST_O  : ST_HIT;
         ST_OZ:    nxt = bit_in ? ST_ZO : ST_LOCK;
         ST_HIT:   nxt = bit_in ? ST_ZO : ST_LOCK;
         ST_LOCK:  nxt = ST_LOCK;
         default:  nxt = ST_EMPTY;
      endcase
   end

   // Moore decode: depends on the stored state only
   assign match  = (cur == ST_HIT);
   assign locked = (cur == ST_LOCK);

endmodule

// File: rtl/gsd_state_reg.sv
module gsd_state_reg
   import gsd_pkg::*;
#(
   parameter int ONE_HOT = 0
)(
   input  logic       clk,
   input  logic       rst,
   input  gsd_state_e nxt,
   output gsd_state_e cur
);

   generate
      if (ONE_HOT == 0) begin : g_binary
         logic [GSD_SW-1:0] q;

         always_ff @(posedge clk) begin
            if (rst) q <= ST_EMPTY;
            else     q <= nxt;
         end

         // unused code falls back to the empty state
         always_comb begin
            if (q <= GSD_LAST) cur = gsd_state_e'(q);
            else               cur = ST_EMPTY;
         end
      end else if (ONE_HOT == 1) begin : g_onehot
         logic [GSD_NS-1:0] q;

         always_ff @(posedge clk) begin
            if (rst) q <= GSD_NS'(1) << ST_EMPTY;
            else     q <= GSD_NS'(1) << nxt;
         end

         // anything but a single hot bit falls back to the empty state
         always_comb begin
            cur = ST_EMPTY;
            if ($onehot(q)) begin
               for (int i = 0; i < GSD_NS; i++) begin
                  if (q[i]) cur = gsd_state_e'(i[GSD_SW-1:0]);
               end
            end
         end
      end else begin : g_bad_enc
         $error("gsd_state_reg: ONE_HOT must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/gated_seq_detect.sv
module gated_seq_detect
   import gsd_pkg::*;
#(
   parameter int ONE_HOT_STATE = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic match_out
);

   gsd_state_e cur;
   gsd_state_e nxt;
   logic       locked;

   gsd_state_reg #(.ONE_HOT(ONE_HOT_STATE)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (cur)
   );

   gsd_next u_next (
      .cur    (cur),
      .bit_in (bit_in),
      .nxt    (nxt),
      .match  (match_out),
      .locked (locked)
   );

endmodule

// File: rtl/gated_seq_detect_chk.sv
module gated_seq_detect_chk (
   input logic clk,
   input logic rst,
   input logic x,
   input logic z,
   input logic locked
);

   // R1: reset empties the history, so no match after a reset edge
   a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !z);

   // R2: a reported match means the last three sampled bits were 0,1,0
   a_r2_match_history: assert property (@(posedge clk) disable iff (rst)
      z |-> (!$past(x, 1) && $past(x, 2) && !$past(x, 3)));

   // R3: a match followed by 1 then 0 reports again (overlap)
   a_r3_overlap: assert property (@(posedge clk) disable iff (rst)
      (z && x) ##1 !x |=> z);

   // R5: lockout persists and keeps the output low
   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      locked |=> (locked && !z));

   // R5: 1,0,0 on three non-reset edges engages the lockout
   a_r5_lock_entry: assert property (@(posedge clk) disable iff (rst)
      (!x && !$past(x, 1) && $past(x, 2) && !$past(rst, 1) && !$past(rst, 2))
      |=> locked);

endmodule

bind gated_seq_detect gated_seq_detect_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .x      (bit_in),
   .z      (match_out),
   .locked (locked)
);

// File: tb/gated_seq_detect_test.sv
module gated_seq_detect_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic match_out;

   int n_checks = 0;
   int n_fails  = 0;

   // scoreboard queues
   bit    exp_q[$];
   string req_q[$];

   // reference model
   bit [2:0] m_hist = 3'b000;
   int       m_cnt  = 0;
   bit       m_lock = 1'b0;
   bit       prev_exp = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   gated_seq_detect uut (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (bit_in),
      .match_out (match_out)
   );

   task automatic check(input string req, input bit act, input bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s at %0t: match_out=%0b expected %0b", req, $time, act, exp);
      end
   endtask

   function automatic bit model_step(input bit b);
      m_hist = {m_hist[1:0], b};
      if (m_cnt < 3) m_cnt++;
      if (m_cnt >= 3 && m_hist == 3'b100) m_lock = 1'b1;
      return (!m_lock && m_cnt >= 3 && m_hist == 3'b010);
   endfunction

   // monitor: compares the output a little after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         check(req_q.pop_front(), match_out, exp_q.pop_front());
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst    = 1'b1;
      bit_in = 1'b1;  // must be ignored (R4)
      m_hist = 3'b000;
      m_cnt  = 0;
      m_lock = 1'b0;
      exp_q.push_back(1'b0);
      req_q.push_back("R1");
      prev_exp = 1'b0;
   endtask

   // drive one bit; expectation either from the model or given literally
   task automatic send_bit(input bit b, input string req, input bit use_lit, input bit lit);
      bit e;
      @(negedge clk);
      rst    = 1'b0;
      bit_in = b;
      #1;
      check("R7", match_out, prev_exp);  // input moved, output must not
      e = model_step(b);
      if (use_lit) e = lit;
      exp_q.push_back(e);
      req_q.push_back(req);
      prev_exp = e;
   endtask

   task automatic send_str(input string s, input string req);
      for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1", req, 1'b0, 1'b0);
   endtask

   task automatic send_vec(input string xs, input string zs);
      for (int i = 0; i < xs.len(); i++) send_bit(xs[i] == "1", "R8", 1'b1, zs[i] == "1");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      do_reset();
      // R8: the two given streams, literal expectations
      send_vec("00101010010", "00010101000");
      do_reset();
      send_vec("11011010010", "00000001000");
      // R2: plain match
      do_reset();
      send_str("010", "R2");
      // R3: overlapped matches
      do_reset();
      send_str("01010", "R3");
      // R4: history before reset is discarded
      do_reset();
      send_str("01", "R4");
      do_reset();
      send_str("0", "R4");
      send_str("11", "R4");
      // R5: lockout holds through later matches
      do_reset();
      send_str("100", "R5");
      send_str("0101010101001010", "R5");
      // R6: reset clears lockout
      do_reset();
      send_str("010", "R6");
      // R2: long random stream with rare resets
      for (int i = 0; i < 10000; i++) begin
         if (($urandom % 800) == 0) do_reset();
         send_bit(1'($urandom), "R2", 1'b0, 1'b0);
      end
      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule